// File: doc/BRIEF.md
# UART Receive-Ready and Clear-To-Send Handshake Controller

This block provides the hardware flow-control handshake of a UART. On the receive side it drives the ready-for-receiving pin (an RTS-style output). The pin can follow the receive FIFO occupancy against a programmable threshold. It can also be set and cleared by software commands through the command strobe. On the transmit side it takes the asynchronous clear-to-send pin through a synchroniser. It reports the synchronised level and pulses a change event for the interrupt logic. When gating is enabled, it only lets the transmitter begin a new character while clear-to-send is active.

The mode word comes from the UART's mode register. Bit 7 selects automatic receive-ready control. Bit 6 enables clear-to-send gating. The threshold is assembled from two separate fields of the same word. The transmitter raises a start request at each character boundary and begins a character only when the permit is high. A character that has already started is never stopped by this block. Software usually programs the threshold to the FIFO depth minus 12, or to the full depth for FIFOs of 12 entries or fewer.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rfr_out`, `cts_now` and `cts_change` are all 0 and the software receive-ready state is 0.
- R2: With `mode_word[7]` = 1, `rfr_out` after a clock edge is 1 when the `rx_count` sampled at that edge is below the threshold, and 0 when it is equal to or above it. A threshold of 0 therefore holds `rfr_out` at 0.
- R3: The threshold is the 16-bit value {`mode_word[17:8]`, `mode_word[5:0]`}: bits 5:0 are its low six bits and bits 17:8 its high ten bits. Bits 7 and 6 are not part of it.
- R4: With `mode_word[7]` = 0, a strobe (`cmd_valid` = 1) with `cmd_code` = 13 sets the software receive-ready state, and `cmd_code` = 14 clears it. `rfr_out` shows the new state right after that clock edge.
- R5: A strobe with any other `cmd_code`, or a code presented with `cmd_valid` = 0, leaves the software receive-ready state unchanged.
- R6: Commands issued while automatic control is on still update the software state. Clearing bit 7 in the same cycle as a code-14 strobe gives `rfr_out` = 0 after that edge.
- R7: `cts_now` equals the `cts_in` level sampled two clock edges earlier (two-flop synchroniser).
- R8: `cts_change` is 1 for exactly one cycle after each change of `cts_now`, and 0 otherwise.
- R9: With `mode_word[6]` = 0, `tx_permit` equals `tx_start_req`. With `mode_word[6]` = 1, `tx_permit` is `tx_start_req` AND `cts_now`. Both are evaluated combinationally in the same cycle.
- R10: `tx_permit` is never 1 without `tx_start_req`, so a character in progress (no new request) is not affected by clear-to-send.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 18 | Mode register: [7] auto receive-ready, [6] CTS gating, {[17:8],[5:0]} threshold |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (13 set, 14 clear receive-ready) |
| rx_count | input | 10 | Receive FIFO occupancy |
| cts_in | input | 1 | Asynchronous clear-to-send pin, 1 = peer ready |
| tx_start_req | input | 1 | Transmitter asks to begin a new character |
| rfr_out | output | 1 | Ready-for-receiving pin, 1 = ready |
| tx_permit | output | 1 | Transmitter may begin the requested character |
| cts_now | output | 1 | Synchronised clear-to-send level |
| cts_change | output | 1 | One-cycle pulse on a change of `cts_now` |

## Verification
The assertions check the following on every cycle: the threshold compare of the receive-ready pin in automatic mode, the immediate response to set and clear commands, the permit rule against gating and the synchronised level, and the pairing of the change pulse with a real change of `cts_now`. Other behaviour can only be shown through the bench's scenarios. These are: that other command codes and unstrobed codes leave the stored state alone, that a command stored under automatic control appears once automatic control is turned off, and that the split threshold field is decoded with the suggested level at its exact boundary. The two-edge synchroniser latency is also covered there.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    localparam int MODE_W      = 18;
    localparam int LVL_LO_W    = 6;
    localparam int LVL_HI_LSB  = 8;
    localparam int LVL_HI_W    = 10;
    localparam int LVL_W       = LVL_LO_W + LVL_HI_W;
    localparam int BIT_AUTO    = 7;
    localparam int BIT_GATE    = 6;
    localparam int CMD_W       = 4;

    localparam logic [CMD_W-1:0] CMD_RDY_SET = 4'd13;
    localparam logic [CMD_W-1:0] CMD_RDY_CLR = 4'd14;

    typedef struct packed {
        logic             auto_rdy;
        logic             cts_gate;
        logic [LVL_W-1:0] level;
    } fc_mode_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2
    } fc_cmd_e;

    function automatic fc_mode_t decode_mode(input logic [MODE_W-1:0] w);
        fc_mode_t m;
        m.auto_rdy = w[BIT_AUTO];
        m.cts_gate = w[BIT_GATE];
        m.level    = {w[LVL_HI_LSB +: LVL_HI_W], w[LVL_LO_W-1:0]};
        return m;
    endfunction

    function automatic fc_cmd_e decode_cmd(input logic v, input logic [CMD_W-1:0] c);
        if (!v)                   return CMD_NONE;
        else if (c == CMD_RDY_SET) return CMD_SET;
        else if (c == CMD_RDY_CLR) return CMD_CLR;
        else                      return CMD_NONE;
    endfunction

    function automatic int suggested_level(input int depth);
        return (depth > 12) ? depth - 12 : depth;
    endfunction

endpackage

// File: rtl/uart_fc_cts_sync.sv
module uart_fc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic level_out,
    output logic change_out
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_out  = chain_q[STAGES-1];
    assign change_out = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/uart_fc_rfr_ctrl.sv
module uart_fc_rfr_ctrl
    import uart_fc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  fc_mode_t         mode,
    input  fc_cmd_e          cmd,
    input  logic [CNT_W-1:0] count,
    output logic             rfr
);
    logic             sw_q, sw_d;
    logic             rfr_q, rfr_d;
    logic [LVL_W-1:0] count_ext;
    logic             at_level;

    assign count_ext = LVL_W'(count);
    assign at_level  = count_ext >= mode.level;

    always_comb begin
        sw_d = sw_q;
        case (cmd)
            CMD_SET: sw_d = 1'b1;
            CMD_CLR: sw_d = 1'b0;
            default: sw_d = sw_q;
        endcase
        rfr_d = mode.auto_rdy ? !at_level : sw_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q  <= 1'b0;
            rfr_q <= 1'b0;
        end else begin
            sw_q  <= sw_d;
            rfr_q <= rfr_d;
        end
    end

    assign rfr = rfr_q;
endmodule

// File: rtl/uart_fc_tx_gate.sv
module uart_fc_tx_gate (
    input  logic start_req,
    input  logic gate_en,
    input  logic cts_ok,
    output logic permit
);
    assign permit = start_req && (!gate_en || cts_ok);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH  = 512,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              cts_in,
    input  logic              tx_start_req,
    output logic              rfr_out,
    output logic              tx_permit,
    output logic              cts_now,
    output logic              cts_change
);
    fc_mode_t mode;
    fc_cmd_e  cmd;

    assign mode = decode_mode(mode_word);
    assign cmd  = decode_cmd(cmd_valid, cmd_code);

    uart_fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (cts_in),
        .level_out  (cts_now),
        .change_out (cts_change)
    );

    uart_fc_rfr_ctrl #(.CNT_W(CNT_W)) u_rfr (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .cmd   (cmd),
        .count (rx_count),
        .rfr   (rfr_out)
    );

    uart_fc_tx_gate u_gate (
        .start_req (tx_start_req),
        .gate_en   (mode.cts_gate),
        .cts_ok    (cts_now),
        .permit    (tx_permit)
    );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk
    import uart_fc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode_word,
    input logic              cmd_valid,
    input logic [CMD_W-1:0]  cmd_code,
    input logic [CNT_W-1:0]  rx_count,
    input logic              tx_start_req,
    input logic              rfr_out,
    input logic              tx_permit,
    input logic              cts_now,
    input logic              cts_change
);
    logic             up_q;
    logic [LVL_W-1:0] lvl;

    always_ff @(posedge clk) up_q <= !rst;

    assign lvl = {mode_word[17:8], mode_word[5:0]};

    // R2, R3: automatic mode follows the threshold compare one edge later
    assert_rfr_auto_R2: assert property (@(posedge clk) disable iff (rst || !up_q)
        mode_word[7] |=> (rfr_out == (LVL_W'($past(rx_count)) < $past(lvl))));

    // R4: set command with automatic mode off
    assert_rfr_set_R4: assert property (@(posedge clk) disable iff (rst || !up_q)
        (!mode_word[7] && cmd_valid && cmd_code == 4'd13) |=> rfr_out);

    // R4, R6: clear command with automatic mode off
    assert_rfr_clr_R4: assert property (@(posedge clk) disable iff (rst || !up_q)
        (!mode_word[7] && cmd_valid && cmd_code == 4'd14) |=> !rfr_out);

    // R9: gating blocks the permit while the synchronised level is low
    assert_permit_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_word[6] && !cts_now) |-> !tx_permit);

    // R9: no gating means the request passes
    assert_permit_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (!mode_word[6] && tx_start_req) |-> tx_permit);

    // R10: no permit without a request
    assert_permit_req_R10: assert property (@(posedge clk) disable iff (rst)
        tx_permit |-> tx_start_req);

    // R8: a change pulse only follows a real change of the synchronised level
    assert_change_real_R8: assert property (@(posedge clk) disable iff (rst || !up_q)
        cts_change |-> (cts_now != $past(cts_now)));

    // R8: without a pulse the level holds
    assert_change_quiet_R8: assert property (@(posedge clk) disable iff (rst || !up_q)
        !cts_change |-> $stable(cts_now));
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_word    (mode_word),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .rx_count     (rx_count),
    .tx_start_req (tx_start_req),
    .rfr_out      (rfr_out),
    .tx_permit    (tx_permit),
    .cts_now      (cts_now),
    .cts_change   (cts_change)
);

// File: tb/sim_uart_flow_ctrl.sv
`timescale 1ns/1ps
module sim_uart_flow_ctrl;
    localparam int DEPTH = 512;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [17:0]   mode_word = '0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_code = '0;
    logic [CW-1:0] rx_count = '0;
    logic          cts_in = 1'b0;
    logic          tx_start_req = 1'b0;
    logic          rfr_out, tx_permit, cts_now, cts_change;

    int n_chk = 0;
    int n_err = 0;

    // bench reference state
    logic m_sw = 1'b0;
    logic m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

    always #2.5 clk = ~clk;

    uart_flow_ctrl #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .mode_word(mode_word), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .rx_count(rx_count), .cts_in(cts_in),
        .tx_start_req(tx_start_req), .rfr_out(rfr_out), .tx_permit(tx_permit),
        .cts_now(cts_now), .cts_change(cts_change)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] make_mode(input logic auto_on, input logic gate_on,
                                              input int level);
        logic [15:0] l;
        l = 16'(level);
        return {l[15:6], auto_on, gate_on, l[5:0]};
    endfunction

    // one clock cycle: drive, check permit, update model, check registered outputs
    task automatic step(input logic [17:0] mw, input logic cv, input logic [3:0] code,
                        input int cnt, input logic cts, input logic req, input string tag);
        logic [15:0] lvl;
        logic        exp_rfr;
        @(negedge clk);
        mode_word = mw; cmd_valid = cv; cmd_code = code;
        rx_count = CW'(cnt); cts_in = cts; tx_start_req = req;
        #1;
        check(mw[6] ? "R9" : "R10", "tx_permit", int'(tx_permit),
              int'(req && (!mw[6] || m_s2)));
        lvl = {mw[17:8], mw[5:0]};
        if (cv && code == 4'd13) m_sw = 1'b1;
        else if (cv && code == 4'd14) m_sw = 1'b0;
        exp_rfr = mw[7] ? (16'(cnt) < lvl) : m_sw;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts;
        @(posedge clk); #1;
        check(tag, "rfr_out", int'(rfr_out), int'(exp_rfr));
        check("R7", "cts_now", int'(cts_now), int'(m_s2));
        check("R8", "cts_change", int'(cts_change), int'(m_s2 != m_s3));
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int lvl500;
        void'($urandom(32'h1F2E3D4C));
        lvl500 = uart_fc_pkg::suggested_level(DEPTH);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "rfr_out", int'(rfr_out), 0);
        check("R1", "cts_now", int'(cts_now), 0);
        check("R1", "cts_change", int'(cts_change), 0);
        step('0, 0, 4'd0, 0, 0, 0, "R1");

        // R4: software set and clear
        step(make_mode(0, 0, 0), 1, 4'd13, 0, 0, 0, "R4");
        step(make_mode(0, 0, 0), 0, 4'd0, 0, 0, 0, "R4");
        step(make_mode(0, 0, 0), 1, 4'd14, 0, 0, 0, "R4");
        step(make_mode(0, 0, 0), 1, 4'd13, 0, 0, 0, "R4");

        // R5: other codes and unstrobed clear leave the state at 1
        step(make_mode(0, 0, 0), 1, 4'd12, 0, 0, 0, "R5");
        step(make_mode(0, 0, 0), 1, 4'd15, 0, 0, 0, "R5");
        step(make_mode(0, 0, 0), 0, 4'd14, 0, 0, 0, "R5");

        // R3: split threshold, suggested level, boundary
        step(make_mode(1, 1, lvl500), 0, 4'd0, lvl500 - 1, 1, 0, "R3");
        step(make_mode(1, 1, lvl500), 0, 4'd0, lvl500, 1, 1, "R3");
        step(make_mode(1, 0, lvl500), 0, 4'd0, lvl500 + 1, 0, 1, "R3");
        step(make_mode(1, 0, 64), 0, 4'd0, 63, 0, 0, "R3");
        step(make_mode(1, 0, 64), 0, 4'd0, 64, 0, 0, "R3");

        // R2: threshold of zero holds the pin low
        step(make_mode(1, 0, 0), 0, 4'd0, 0, 1, 0, "R2");

        // R6: clear stored under automatic control, seen once automatic turns off
        step(make_mode(1, 0, 100), 1, 4'd14, 3, 1, 0, "R6");
        step(make_mode(0, 0, 100), 0, 4'd0, 3, 1, 0, "R6");
        step(make_mode(1, 0, 100), 1, 4'd13, 3, 0, 0, "R6");
        step(make_mode(0, 0, 100), 1, 4'd14, 3, 0, 0, "R6");

        // R9, R10: gating while CTS toggles
        for (int i = 0; i < 8; i++)
            step(make_mode(0, 1, 0), 0, 4'd0, 0, logic'(i[1]), 1, "R4");

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int          lv, cn, off;
            logic        au, gt, cv, ct, rq;
            logic [3:0]  cd;
            lv  = $urandom_range(0, DEPTH);
            off = $urandom_range(0, 4);
            cn  = lv + off - 2;
            if (cn < 0) cn = 0;
            if (cn > DEPTH) cn = DEPTH;
            au = logic'($urandom_range(0, 1));
            gt = logic'($urandom_range(0, 1));
            cv = logic'($urandom_range(0, 1));
            cd = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                             : 4'($urandom_range(13, 14));
            ct = ($urandom_range(0, 3) == 0) ? ~m_s1 : m_s1;
            rq = logic'($urandom_range(0, 1));
            step(make_mode(au, gt, lv), cv, cd, cn, ct, rq, au ? "R2" : "R4");
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule